// File: doc/BRIEF.md
# Composite Video Line and Frame Timing Generator

This block turns a single clock (16 MHz in the target system) into the line and frame timing of a low-resolution, non-interlaced composite picture. It drives one byte-wide video port. The top nibble carries pixel intensity. One bit marks vertical sync and one bit marks horizontal sync. The two lowest bits are always zero.

A pixel source further downstream gets two signals from the block. A window strobe marks the clocks where picture data is shown. A line index gives the active line in progress. The source answers on a 4-bit intensity input.

Every line has the same four regions: the sync pulse, the back porch, the picture window and the front porch. A frame runs through four groups of lines in a fixed order: the picture lines, black lines before vertical sync, vertical-sync lines, and black lines after vertical sync. The frame then repeats. On vertical-sync lines the vsync bit is held high for the whole line, and the horizontal pulse is still marked on top of it.

Top module: `sync_timing_gen`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge. The first edge after `rst` falls puts out phase 0 of picture line 0.
- R2: Every line lasts HS_LEN+BP_LEN+ACT_LEN+FP_LEN clocks (defaults 76, 128, 720, 73, which gives 997). Bit 2 of `video_out` is 1 for exactly the first HS_LEN clocks of each line.
- R3: `pix_window` is high on picture lines only, for the ACT_LEN clocks that start HS_LEN+BP_LEN clocks into the line. It is never high together with bit 2 or bit 3.
- R4: While `pix_window` is high, bits 7:4 of `video_out` equal the value `pix_in` had at the preceding rising edge. During the sync pulse a picture line reads 0x04, and elsewhere it reads 0x00.
- R5: The line groups follow each other in this order: ACT_LINES picture lines, PRE_LINES black lines, VS_LINES vertical-sync lines, POST_LINES black lines, and then picture line 0 again (defaults 240, 3, 3, 14).
- R6: On vertical-sync lines `video_out` is 0x0C during the sync pulse and 0x08 for the rest of the line.
- R7: On black lines `video_out` is 0x04 during the sync pulse and 0x00 otherwise, whatever `pix_in` carries. Bits 7:4 are zero whenever `pix_window` is low.
- R8: `line_num` gives the index of the current picture line, counted from 0. It reads 0 on all other lines.
- R9: `frame_start` is high for exactly one clock, on the first clock of picture line 0. In that clock `video_out` is 0x04.
- R10: Bits 1:0 of `video_out` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 4 | Pixel intensity from the downstream source |
| video_out | output | 8 | Video byte: bits 7:4 intensity, bit 3 vsync, bit 2 hsync |
| pix_window | output | 1 | High while picture data is shown |
| line_num | output | LNW | Current picture line index |
| frame_start | output | 1 | One-clock pulse at the start of a frame |

## Verification
The wrap from the last black line after vertical sync back to picture line 0 is where the most happens in one clock. The line counter, the group change, the start of the sync pulse and the frame pulse all fall together there. The bench runs small parameters through two whole frames and compares every clock with a model that works from the elapsed cycle count alone, so the wrap clock is checked for 0x04, `frame_start` and line index 0 at once. A reset given in the middle of a vertical-sync line checks that reset beats the ongoing sequence in that same clock.

// File: rtl/sync_timing_gen.sv
module sync_timing_gen #(
  parameter int HS_LEN     = 76,
  parameter int BP_LEN     = 128,
  parameter int ACT_LEN    = 720,
  parameter int FP_LEN     = 73,
  parameter int ACT_LINES  = 240,
  parameter int PRE_LINES  = 3,
  parameter int VS_LINES   = 3,
  parameter int POST_LINES = 14,
  localparam int LNW = (ACT_LINES > 1) ? $clog2(ACT_LINES) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     pix_in,
  output logic [7:0]     video_out,
  output logic           pix_window,
  output logic [LNW-1:0] line_num,
  output logic           frame_start
);

  localparam int LINE_LEN = HS_LEN + BP_LEN + ACT_LEN + FP_LEN;
  localparam int PW       = $clog2(LINE_LEN);
  localparam int WIN_LO   = HS_LEN + BP_LEN;
  localparam int WIN_HI   = WIN_LO + ACT_LEN;
  localparam int MAX_A    = (ACT_LINES > PRE_LINES) ? ACT_LINES : PRE_LINES;
  localparam int MAX_B    = (VS_LINES > POST_LINES) ? VS_LINES : POST_LINES;
  localparam int MAXL     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(MAXL + 1);

  typedef enum logic [1:0] {SEG_ACT, SEG_PRE, SEG_VS, SEG_POST} seg_t;

  seg_t          seg;
  logic [PW-1:0] phase;
  logic [CW-1:0] lcnt;
  logic [CW-1:0] seg_lines;

  always_comb begin
    case (seg)
      SEG_ACT: seg_lines = CW'(ACT_LINES);
      SEG_PRE: seg_lines = CW'(PRE_LINES);
      SEG_VS:  seg_lines = CW'(VS_LINES);
      default: seg_lines = CW'(POST_LINES);
    endcase
  end

  wire line_end = (phase == PW'(LINE_LEN - 1));
  wire seg_end  = (lcnt == seg_lines - CW'(1));
  wire hs_now   = (phase < PW'(HS_LEN));
  wire in_win   = (phase >= PW'(WIN_LO)) && (phase < PW'(WIN_HI));
  wire act_seg  = (seg == SEG_ACT);
  wire vs_seg   = (seg == SEG_VS);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      lcnt  <= '0;
      seg   <= SEG_ACT;
    end else begin
      phase <= line_end ? '0 : phase + PW'(1);
      if (line_end) begin
        if (seg_end) begin
          lcnt <= '0;
          seg  <= seg_t'(seg + 2'd1);
        end else begin
          lcnt <= lcnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      video_out   <= '0;
      pix_window  <= 1'b0;
      line_num    <= '0;
      frame_start <= 1'b0;
    end else begin
      video_out   <= {(act_seg && in_win) ? pix_in : 4'h0, vs_seg, hs_now, 2'b00};
      pix_window  <= act_seg && in_win;
      line_num    <= act_seg ? LNW'(lcnt) : '0;
      frame_start <= act_seg && (lcnt == '0) && (phase == '0);
    end
  end

  p_frame_start_sync_r9: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (video_out == 8'h04) && (line_num == '0));

  p_window_clear_of_sync_r3: assert property (@(posedge clk) disable iff (rst)
    pix_window |-> (video_out[3:2] == 2'b00));

  p_vsync_enters_on_hsync_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(video_out[3]) |-> video_out[2]);

  p_nibble_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !pix_window |-> (video_out[7:4] == 4'h0));

endmodule

// File: tb/sync_timing_gen_test.sv
module sync_timing_gen_test;
  localparam int HS = 4, BP = 5, ACT = 8, FP = 3;
  localparam int AL = 4, PL = 2, VL = 2, QL = 3;
  localparam int LINE = HS + BP + ACT + FP;
  localparam int FRAME_LINES = AL + PL + VL + QL;
  localparam int LNW = $clog2(AL);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] pix_in = 4'h0;
  logic [7:0] video_out;
  logic pix_window;
  logic [LNW-1:0] line_num;
  logic frame_start;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sync_timing_gen #(.HS_LEN(HS), .BP_LEN(BP), .ACT_LEN(ACT), .FP_LEN(FP),
    .ACT_LINES(AL), .PRE_LINES(PL), .VS_LINES(VL), .POST_LINES(QL)) uut (
    .clk(clk), .rst(rst), .pix_in(pix_in), .video_out(video_out),
    .pix_window(pix_window), .line_num(line_num), .frame_start(frame_start));

  function automatic logic [3:0] pat(input int t);
    return 4'((t * 7 + 3) % 16);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got 0x%0h expected 0x%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    pix_in = pat(cyc);
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic compare_model();
    int t, ph, ln, lidx, seg;
    logic hs, win, vs;
    logic [3:0] nib;
    t  = cyc - 1;
    ph = t % LINE;
    ln = (t / LINE) % FRAME_LINES;
    if (ln < AL) begin seg = 0; lidx = ln; end
    else if (ln < AL + PL) begin seg = 1; lidx = 0; end
    else if (ln < AL + PL + VL) begin seg = 2; lidx = 0; end
    else begin seg = 3; lidx = 0; end
    hs  = ph < HS;
    win = (seg == 0) && (ph >= HS + BP) && (ph < HS + BP + ACT);
    vs  = (seg == 2);
    nib = win ? pat(t) : 4'h0;
    chk("R2 hsync bit", int'(video_out[2]), int'(hs));
    chk("R3 window", int'(pix_window), int'(win));
    chk("R5 vsync bit", int'(video_out[3]), int'(vs));
    chk("R10 low bits", int'(video_out[1:0]), 0);
    chk("R8 line index", int'(line_num), lidx);
    chk("R9 frame pulse", int'(frame_start), int'(t % (LINE * FRAME_LINES) == 0));
    if (seg == 0)      chk("R4 picture byte", int'(video_out), int'({nib, 1'b0, hs, 2'b00}));
    else if (seg == 2) chk("R6 vsync byte", int'(video_out), hs ? 8'h0C : 8'h08);
    else               chk("R7 black byte", int'(video_out), hs ? 8'h04 : 8'h00);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset video", int'(video_out), 0);
    chk("R1 reset window", int'(pix_window), 0);
    chk("R1 reset line", int'(line_num), 0);
    chk("R1 reset pulse", int'(frame_start), 0);
    rst = 1'b0;
    cyc = 0;
    step();
    chk("R1 first line start", int'(video_out), 8'h04);
    chk("R9 first pulse", int'(frame_start), 1);
  endtask

  task automatic t_two_frames();
    compare_model();
    for (int i = 1; i < 2 * LINE * FRAME_LINES + LINE; i++) begin
      step();
      compare_model();
    end
  endtask

  task automatic t_reset_in_vsync();
    while (((cyc / LINE) % FRAME_LINES) != AL + PL) step();
    repeat (LINE / 2) step();
    chk("R6 before reset", int'(video_out), 8'h08);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset over vsync", int'(video_out), 0);
    chk("R1 reset over vsync line", int'(line_num), 0);
    rst = 1'b0;
    cyc = 0;
    for (int i = 0; i < LINE * (AL + 1); i++) begin
      step();
      compare_model();
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_two_frames();
        t_reset_in_vsync();
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule